// File: doc/BRIEF.md
# Reconfigurable Binary Correlation Tap Array

This block holds 256 one-bit reference taps, organised as eight 32-tap stages, and compares them against a stream of input samples. Each tap shifts its data bit along the stage and compares it with its own reference bit. A match counts only when the tap's mask bit is set. Every clock, each stage reports a registered count of its unmasked matches. A downstream weight-and-sum unit combines these counts into a correlation score.

A five-bit window code sets how the stages are linked. A stage that heads a chain takes its data from its own input pin. Any other stage takes the bit that leaves the end of the stage above it. With 1-, 2-, 4- or 8-bit samples, this gives windows of 256, 128, 64 or 32 taps. The same linking also serves two-dimensional windows, where each chain is one row. The array can be split into two independent halves. The bit leaving the end of each chain is returned on the data output pin of that chain's head.

Reference and mask values are staged outside the block on preload inputs. They are copied into the taps only on a clock edge with the active-low transfer strobe low. Shifting and counting carry on through a transfer without a pause.

Top module: `bin_corr_array`

## Requirements
- R1: While `rst_n` is low at a rising edge, all shift taps, reference latches, mask latches and stage counts clear to 0, so `stage_cnt` and `dout` read 0.
- R2: Stage s count (`stage_cnt[6*s+5:6*s]`) equals the number of its taps whose data bit equals its reference bit (XNOR) and whose mask bit is 1. It is computed from the tap state after edge t and appears after edge t+1. Its range is 0 to 32.
- R3: A tap whose mask bit is 0 adds nothing to the count. A stage whose 32 mask bits are all 0 reports 0.
- R4: Tap 0 of a stage receives that stage's input bit at each edge, and tap k holds the bit received k edges earlier. Tap 31 is the stage tail. Preload bit 32*s+k (`pre_ref`, `pre_mask`) belongs to tap k of stage s.
- R5: At a rising edge with `xfer_n` low, every reference and mask latch loads its preload bit. With `xfer_n` high, the latches keep their values whatever the preload inputs do. Shifting and counting continue in both cases.
- R6: `win_cfg[1:0]` values 0, 1, 2 and 3 give chains of 8, 4, 2 and 1 stages (256, 128, 64, 32 taps). Chain heads are stage 7 and every stage whose distance below stage 7 is a multiple of the chain length.
- R7: Stage 7 always takes `din[7]`. Any other head stage s takes `din[s]`, and any non-head stage s takes the tail of stage s+1.
- R8: `win_cfg[2]` = 1 additionally makes stage 3 a head, splitting the array into an upper half (stages 7..4) and a lower half (stages 3..0). With `win_cfg[1:0]` = 0, this gives two 128-tap chains.
- R9: For each head stage h, `dout[h]` is the tail of the last stage of the chain that h heads, with no added register. `dout` bits of non-head stages are 0.
- R10: Any `win_cfg` with bit 3 or bit 4 set is handled as code 0: a single 256-tap chain with no split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| win_cfg | input | 5 | Window code: [1:0] chain length, [2] split, [4:3] must be 0 |
| din | input | 8 | Per-stage data input pins |
| xfer_n | input | 1 | Active-low transfer strobe from preload to tap latches |
| pre_ref | input | 256 | Preloaded reference bits, bit 32*s+k for stage s tap k |
| pre_mask | input | 256 | Preloaded mask bits, same bit order as `pre_ref` |
| dout | output | 8 | Chain-end data returned on the head stage's bit |
| stage_cnt | output | 48 | Eight 6-bit match counts, stage s at bits 6*s+5:6*s |

## Verification
A data bit driven before edge t sits in tap 0 after edge t and is counted in `stage_cnt` after edge t+1. The chain-end bit on `dout` changes right after the edge that shifts it, because `dout` has no register of its own. A transfer at edge t affects the count that appears after edge t+1. The bench's behavioural model follows this timing. At each rising edge it first computes the counts due at the next edge from its pre-edge state, then shifts and transfers. All outputs are compared at the following falling edge, under random data across every window code, including split and invalid codes, masked stages, and transfers made while data keeps flowing.

// File: rtl/corr_pkg.sv
// Shared definitions for the correlation tap array.
// Assumes the window code width is fixed by the surrounding datapath.
package corr_pkg;
    localparam int CFG_W = 5;

    // Chain-length selector held in the low two bits of the window code.
    typedef enum logic [1:0] {
        SPAN_ALL     = 2'd0,
        SPAN_HALF    = 2'd1,
        SPAN_QUARTER = 2'd2,
        SPAN_EIGHTH  = 2'd3
    } span_sel_e;
endpackage

// File: rtl/corr_preload_latch.sv
// Tap reference and mask latches, loaded from the preload bus.
// Loads on a rising edge while the active-low strobe is low, holds otherwise.
// Assumes the preload bus is stable for the edge it is transferred on.
module corr_preload_latch #(
    parameter int WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_n,
    input  logic [WIDTH-1:0] pre_ref,
    input  logic [WIDTH-1:0] pre_mask,
    output logic [WIDTH-1:0] ref_q,
    output logic [WIDTH-1:0] mask_q
);

    // Capture the preload values on a transfer edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            mask_q <= '0;
        end else if (!xfer_n) begin
            ref_q  <= pre_ref;
            mask_q <= pre_mask;
        end
    end

    AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_n |=> (ref_q == $past(pre_ref)) && (mask_q == $past(pre_mask))); // R5
    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_n |=> $stable(ref_q) && $stable(mask_q)); // R5

endmodule

// File: rtl/corr_tap_stage.sv
// One correlator stage: a shift line of taps with a registered match count.
// Each tap matches when its data bit equals its reference bit and its mask is set.
// Assumes reference and mask are held stable by the latch unit.
module corr_tap_stage #(
    parameter int TAPS = 32,
    parameter int CNTW = $clog2(TAPS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sin,
    input  logic [TAPS-1:0] ref_bits,
    input  logic [TAPS-1:0] mask_bits,
    output logic [TAPS-1:0] taps,
    output logic [CNTW-1:0] cnt
);

    logic [TAPS-1:0] hit;
    logic [CNTW-1:0] cnt_d;

    // Per-tap XNOR compare gated by the mask.
    always_comb hit = ~(taps ^ ref_bits) & mask_bits;

    // Population count of the gated matches.
    always_comb begin
        cnt_d = '0;
        for (int k = 0; k < TAPS; k++) begin
            cnt_d = cnt_d + CNTW'(hit[k]);
        end
    end

    // Shift the newest bit into tap 0.
    always_ff @(posedge clk) begin
        if (!rst_n) taps <= '0;
        else        taps <= {taps[TAPS-2:0], sin};
    end

    // Register the stage count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(TAPS)); // R2
    AST_MASK_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_bits == '0) |=> (cnt == '0)); // R3
    AST_SHIFT_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (taps[TAPS-1:1] == $past(taps[TAPS-2:0])) && (taps[0] == $past(sin))); // R4

endmodule

// File: rtl/corr_window_route.sv
// Window decode and stage routing for the correlation array.
// Picks chain heads from the window code, feeds each stage from its pin or
// from the stage above, and returns chain-end bits on the head's output bit.
// Assumes stage N-1 is the top of the array; invalid codes fall back to code 0.
module corr_window_route
    import corr_pkg::*;
#(
    parameter int N_STAGES = 8
) (
    input  logic [CFG_W-1:0]    win_cfg,
    input  logic [N_STAGES-1:0] din,
    input  logic [N_STAGES-1:0] tail,
    output logic [N_STAGES-1:0] head,
    output logic [N_STAGES-1:0] stage_in,
    output logic [N_STAGES-1:0] dout
);

    localparam int TOP        = N_STAGES - 1;
    localparam int SPLIT_HEAD = N_STAGES / 2 - 1;

    logic                code_ok;
    logic                split;
    span_sel_e           span_sel;
    logic [N_STAGES-1:0] chain_out;

    // Validate the code and pull out the span and split fields.
    always_comb begin
        code_ok  = (win_cfg[CFG_W-1:3] == '0);
        span_sel = code_ok ? span_sel_e'(win_cfg[1:0]) : SPAN_ALL;
        split    = code_ok & win_cfg[2];
    end

    // Mark the stages that start a chain.
    always_comb begin
        int span;
        span = N_STAGES >> int'(span_sel);
        if (span < 1) span = 1;
        for (int s = 0; s < N_STAGES; s++) begin
            head[s] = (((TOP - s) % span) == 0) || (split && (s == SPLIT_HEAD));
        end
    end

    // Feed each stage from its own pin or from the tail of the stage above.
    always_comb begin
        stage_in[TOP] = din[TOP];
        for (int s = 0; s < TOP; s++) begin
            stage_in[s] = head[s] ? din[s] : tail[s + 1];
        end
    end

    // Find the chain-end bit for every stage and expose it on head bits.
    always_comb begin
        chain_out[0] = tail[0];
        for (int s = 1; s < N_STAGES; s++) begin
            chain_out[s] = head[s - 1] ? tail[s] : chain_out[s - 1];
        end
        dout = head & chain_out;
    end

endmodule

// File: rtl/bin_corr_array.sv
// Top of the reconfigurable binary correlation tap array.
// Eight stages of taps, routed by the window code, with shared preload latches.
// Assumes downstream logic weights and sums the per-stage counts.
module bin_corr_array
    import corr_pkg::*;
#(
    parameter int N_STAGES   = 8,
    parameter int STAGE_TAPS = 32
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [CFG_W-1:0]                         win_cfg,
    input  logic [N_STAGES-1:0]                      din,
    input  logic                                     xfer_n,
    input  logic [N_STAGES*STAGE_TAPS-1:0]           pre_ref,
    input  logic [N_STAGES*STAGE_TAPS-1:0]           pre_mask,
    output logic [N_STAGES-1:0]                      dout,
    output logic [N_STAGES*$clog2(STAGE_TAPS+1)-1:0] stage_cnt
);

    localparam int TOTAL = N_STAGES * STAGE_TAPS;
    localparam int CNTW  = $clog2(STAGE_TAPS + 1);

    logic [TOTAL-1:0]      ref_q;
    logic [TOTAL-1:0]      mask_q;
    logic [N_STAGES-1:0]   head;
    logic [N_STAGES-1:0]   stage_in;
    logic [N_STAGES-1:0]   tail;
    logic [STAGE_TAPS-1:0] stage_taps [N_STAGES];

    corr_preload_latch #(.WIDTH(TOTAL)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_n   (xfer_n),
        .pre_ref  (pre_ref),
        .pre_mask (pre_mask),
        .ref_q    (ref_q),
        .mask_q   (mask_q)
    );

    corr_window_route #(.N_STAGES(N_STAGES)) u_route (
        .win_cfg  (win_cfg),
        .din      (din),
        .tail     (tail),
        .head     (head),
        .stage_in (stage_in),
        .dout     (dout)
    );

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        corr_tap_stage #(.TAPS(STAGE_TAPS), .CNTW(CNTW)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .sin       (stage_in[s]),
            .ref_bits  (ref_q[s*STAGE_TAPS +: STAGE_TAPS]),
            .mask_bits (mask_q[s*STAGE_TAPS +: STAGE_TAPS]),
            .taps      (stage_taps[s]),
            .cnt       (stage_cnt[s*CNTW +: CNTW])
        );

        // Tail of each stage feeds the router.
        always_comb tail[s] = stage_taps[s][STAGE_TAPS-1];

        AST_HEAD_FEED: assert property (@(posedge clk) disable iff (!rst_n)
            head[s] |=> (stage_taps[s][0] == $past(din[s]))); // R7

        if (s < N_STAGES - 1) begin : g_link
            AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
                !head[s] |=> (stage_taps[s][0] == $past(stage_taps[s+1][STAGE_TAPS-1]))); // R7
        end
    end

    AST_TOP_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage_taps[N_STAGES-1][0] == $past(din[N_STAGES-1]))); // R7

endmodule

// File: tb/bin_corr_array_test.sv
`timescale 1ns/1ps
module bin_corr_array_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   win_cfg = '0;
    logic [7:0]   din = '0;
    logic         xfer_n = 1'b1;
    logic [255:0] pre_ref = '0;
    logic [255:0] pre_mask = '0;
    logic [7:0]   dout;
    logic [47:0]  stage_cnt;

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    // Behavioural model: a 256-position delay line, position 32*(7-s)+k is stage s tap k.
    bit line  [256];
    bit mref  [256];
    bit mmask [256];
    int ecnt  [8];

    bin_corr_array uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_cfg   (win_cfg),
        .din       (din),
        .xfer_n    (xfer_n),
        .pre_ref   (pre_ref),
        .pre_mask  (pre_mask),
        .dout      (dout),
        .stage_cnt (stage_cnt)
    );

    always #4 clk = ~clk;

    function automatic int pos(int s, int k);
        return 32 * (7 - s) + k;
    endfunction

    // Heads from the window code (R6, R8, R10).
    function automatic bit [7:0] heads(bit [4:0] c);
        bit [7:0] h;
        int span;
        if (c[4:3] != 0) c = 5'd0;
        span = 8 >> c[1:0];
        for (int s = 0; s < 8; s++)
            h[s] = (((7 - s) % span) == 0) || (c[2] && s == 3);
        return h;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic model_step();
        bit [7:0] h;
        if (!rst_n) begin
            for (int g = 0; g < 256; g++) begin
                line[g] = 0; mref[g] = 0; mmask[g] = 0;
            end
            for (int s = 0; s < 8; s++) ecnt[s] = 0;
            return;
        end
        for (int s = 0; s < 8; s++) begin
            ecnt[s] = 0;
            for (int k = 0; k < 32; k++)
                if (mmask[s*32+k] && (line[pos(s, k)] == mref[s*32+k])) ecnt[s]++;
        end
        h = heads(win_cfg);
        for (int g = 255; g > 0; g--) line[g] = line[g-1];
        for (int s = 0; s < 8; s++)
            if (h[s]) line[pos(s, 0)] = din[s];
        if (!xfer_n) begin
            for (int g = 0; g < 256; g++) begin
                mref[g] = pre_ref[g]; mmask[g] = pre_mask[g];
            end
        end
    endtask

    task automatic check_all();
        bit [7:0] h;
        bit [7:0] edout;
        h = heads(win_cfg);
        edout = '0;
        for (int s = 7; s >= 0; s--) begin
            if (h[s] && rst_n) begin
                int e;
                e = s;
                while (e > 0 && !h[e-1]) e--;
                edout[s] = line[pos(e, 31)];
            end
        end
        for (int s = 0; s < 8; s++) begin
            n_vec++;
            if (int'(stage_cnt[s*6 +: 6]) != ecnt[s]) begin
                n_fail++;
                $display("FAIL %s stage %0d count: actual %0d expected %0d",
                         cur_req, s, stage_cnt[s*6 +: 6], ecnt[s]);
            end
        end
        n_vec++;
        if (dout !== edout) begin
            n_fail++;
            $display("FAIL %s dout: actual %h expected %h", cur_req, dout, edout);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            din = 8'($urandom);
            tick();
        end
    endtask

    initial begin
        // R1: reset clears everything.
        cur_req = "R1";
        pre_ref = rnd256(); pre_mask = '1; xfer_n = 1'b0; din = 8'hff;
        repeat (3) tick();
        rst_n = 1'b1; xfer_n = 1'b1;
        run(5);

        // R5: transfer loads, later preload changes without strobe are ignored.
        cur_req = "R5";
        pre_ref = rnd256(); pre_mask = '1; xfer_n = 1'b0;
        tick();
        xfer_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            pre_ref = rnd256(); pre_mask = rnd256();
            din = 8'($urandom);
            tick();
        end

        // R2: all-zero reference, zero data gives full count, then all ones gives none.
        cur_req = "R2";
        pre_ref = '0; pre_mask = '1; xfer_n = 1'b0;
        tick();
        xfer_n = 1'b1;
        din = 8'h00; repeat (300) tick();
        din = 8'hff; repeat (300) tick();

        // R4: a single marker bit walks through the 256-tap line.
        cur_req = "R4";
        pre_ref = '0; pre_ref[0] = 1'b1; pre_ref[37] = 1'b1; pre_ref[255] = 1'b1;
        xfer_n = 1'b0; din = 8'h80; tick();
        xfer_n = 1'b1; din = 8'h00; repeat (260) tick();

        // R3: random masks with stage 5 masked off entirely.
        cur_req = "R3";
        pre_ref = rnd256(); pre_mask = rnd256(); pre_mask[5*32 +: 32] = '0;
        xfer_n = 1'b0; tick(); xfer_n = 1'b1;
        run(80);

        // R6: each chain length, with a transfer mid-stream.
        cur_req = "R6";
        pre_mask = '1;
        for (int c = 0; c < 4; c++) begin
            win_cfg = 5'(c);
            run(60);
            pre_ref = rnd256(); xfer_n = 1'b0; din = 8'($urandom); tick(); xfer_n = 1'b1;
            run(60);
        end

        // R7: every stage fed from its own pin.
        cur_req = "R7";
        win_cfg = 5'd3; run(80);

        // R8: split halves with full and half chain lengths.
        cur_req = "R8";
        win_cfg = 5'd4; run(150);
        win_cfg = 5'd5; run(80);

        // R9: chain-end bits with two-stage chains and a fresh transfer.
        cur_req = "R9";
        win_cfg = 5'd2;
        pre_ref = rnd256(); pre_mask = rnd256(); xfer_n = 1'b0; din = 8'($urandom); tick();
        xfer_n = 1'b1; run(100);

        // R10: invalid codes behave as the single 256-tap chain.
        cur_req = "R10";
        win_cfg = 5'd8;  run(60);
        win_cfg = 5'd22; run(60);
        win_cfg = 5'd31; run(60);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule